// File: doc/BRIEF.md
# Infrared Receiver Interrupt Controller

This block gathers the interrupt causes of a consumer-infrared receive port and drives one active-high host interrupt line. There are three causes: the receive buffer reaching its programmed fill level (or holding stale data for too long), a line error reported by the receiver, and the expiry of a down-counting timer. Each cause is latched in a status register. Each cause also has its own enable bit, and one master enable bit sits above all of them.

The surrounding receive logic supplies the buffer fill level, a pulse for every byte written into the buffer, pulses for the four error kinds, and read strobes for the line-status and receive-buffer registers. The timer supplies a timer-run enable and a pulse when the count reaches zero. The block also contains an idle counter. That counter sets the receive cause when data sits below the threshold with no buffer traffic for `TMO_CYC` cycles.

Top module: `irrx_irq_ctrl`

## Requirements
- R1: The enable register resets to 0x00. A write with `cfg_we` stores bits 7 (master), 2 (timer), 1 (line) and 0 (receive) on the next edge. Bits 6..3 always read 0.
- R2: The status register resets to 0x00. Bit 2 is the timer cause, bit 1 the line cause and bit 0 the receive cause. Bits 7..3 always read 0.
- R3: Status bit 2 sets on the edge where `tmr_zero` is high, but only if both `tmr_run_en` and enable bit 2 are 1 in that cycle. Otherwise a `tmr_zero` pulse leaves it unchanged.
- R4: A `stat_rd` pulse clears status bit 2. If a timer set arrives in the same cycle, the set wins.
- R5: Any of `err_overrun`, `err_parity`, `err_stop` or `err_silent` sets status bit 1 on the next edge. An `lsr_rd` pulse clears it. A set in the same cycle as `lsr_rd` wins.
- R6: Status bit 0 is set on any edge where `fill_lvl >= rx_thresh`, compared as unsigned values. A threshold of 0 therefore keeps it set.
- R7: Suppose `fill_lvl` is nonzero and below `rx_thresh`, and no `byte_in` or `rbr_rd` pulse arrives. The idle counter reloads on each `byte_in` or `rbr_rd` edge. Status bit 0 sets on the edge `TMO_CYC+1` edges after the last reload edge. Each expiry also reloads the counter.
- R8: An `rbr_rd` pulse clears status bit 0 if, in that cycle, the fill level is below the threshold and no timeout is expiring. Otherwise the bit stays set.
- R9: `irq` is high exactly when enable bit 7 is 1 and, for at least one cause n in {0,1,2}, both status bit n and enable bit n are 1. It follows the registers combinationally.
- R10: Clearing an enable bit drops its contribution to `irq` but leaves the latched status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 8 | Enable register write data |
| stat_rd | input | 1 | Status register read strobe (clears timer cause) |
| tmr_run_en | input | 1 | Timer running enable |
| tmr_zero | input | 1 | Timer reached zero pulse |
| err_overrun | input | 1 | Overrun error pulse |
| err_parity | input | 1 | Parity error pulse |
| err_stop | input | 1 | Stop-bit error pulse |
| err_silent | input | 1 | Silent-byte error pulse |
| lsr_rd | input | 1 | Line-status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| byte_in | input | 1 | Byte written into receive buffer |
| fill_lvl | input | LVL_W | Receive buffer fill level |
| rx_thresh | input | LVL_W | Receive interrupt threshold |
| en_reg | output | 8 | Enable register contents |
| stat_reg | output | 8 | Status register contents |
| irq | output | 1 | Host interrupt, active high |

## Verification
Every cause latch can be seen directly on `stat_reg` one edge after its stimulus, so a wrong set or clear decision shows up at the ports within a single cycle. A fault in the idle counter shows up instead as status bit 0 rising one or more edges early or late against the `TMO_CYC+1` count. That fault appears only after a full idle window, so the window is watched edge by edge, including a window that restarts midway. A wrong masking term in `irq` is visible combinationally as soon as the enable write lands. To catch it, every combination of the four enable bits is swept against fixed status patterns.

// File: rtl/irrx_irq_pkg.sv
package irrx_irq_pkg;
  localparam int unsigned GLB_BIT = 7;
  localparam int unsigned TMR_BIT = 2;
  localparam int unsigned LSR_BIT = 1;
  localparam int unsigned RXL_BIT = 0;
  localparam logic [7:0]  EN_MASK = 8'h87;
  localparam logic [7:0]  ST_MASK = 8'h07;

  // master enable gating the OR of per-cause enabled status bits
  function automatic logic irq_merge(input logic [7:0] en, input logic [7:0] st);
    return en[GLB_BIT] & (|(en & st & ST_MASK));
  endfunction
endpackage

// File: rtl/irrx_en_reg.sv
module irrx_en_reg
  import irrx_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= 8'h00;
    else if (we) en_q <= wdata & EN_MASK;
  end

  assert_en_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (en_q == ($past(wdata) & EN_MASK)));
  assert_en_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en_q));
endmodule

// File: rtl/irrx_evt_latch.sv
module irrx_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (set_i)  q <= 1'b1;
    else if (clr_i)  q <= 1'b0;
  end

  // set dominates clear (R4 timer, R5 line)
  assert_latch_set_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  assert_latch_clr_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q);
  assert_latch_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/irrx_rx_tmo.sv
module irrx_rx_tmo #(
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned TMO_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill,
  input  logic [LVL_W-1:0] thresh,
  input  logic             byte_in,
  input  logic             rbr_rd,
  output logic             level_hit,
  output logic             tmo_fire,
  output logic             st_rx
);
  localparam int unsigned     CNT_W    = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TMO_CYC);

  function automatic logic lvl_reached(input logic [LVL_W-1:0] f,
                                       input logic [LVL_W-1:0] t);
    return f >= t;
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             has_data;
  logic             reload;

  assign has_data  = (fill != '0);
  assign level_hit = lvl_reached(fill, thresh);
  assign tmo_fire  = (cnt == '0) && has_data && !level_hit;
  assign reload    = byte_in | rbr_rd | !has_data | tmo_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= CNT_LOAD;
    else if (reload)     cnt <= CNT_LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_rx <= 1'b0;
    else        st_rx <= level_hit | tmo_fire | (st_rx & ~rbr_rd);
  end

  assert_level_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    level_hit |=> st_rx);
  assert_tmo_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> st_rx);
  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LOAD);
  assert_tmo_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in || rbr_rd) |=> !tmo_fire);
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !level_hit && !tmo_fire) |=> !st_rx);
endmodule

// File: rtl/irrx_irq_ctrl.sv
module irrx_irq_ctrl
  import irrx_irq_pkg::*;
#(
  parameter int unsigned LVL_W   = 5,
  parameter int unsigned TMO_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  input  logic             stat_rd,
  input  logic             tmr_run_en,
  input  logic             tmr_zero,
  input  logic             err_overrun,
  input  logic             err_parity,
  input  logic             err_stop,
  input  logic             err_silent,
  input  logic             lsr_rd,
  input  logic             rbr_rd,
  input  logic             byte_in,
  input  logic [LVL_W-1:0] fill_lvl,
  input  logic [LVL_W-1:0] rx_thresh,
  output logic [7:0]       en_reg,
  output logic [7:0]       stat_reg,
  output logic             irq
);
  localparam int unsigned N_LATCH = 2;  // 0: line cause, 1: timer cause

  logic [7:0]         en_q;
  logic [N_LATCH-1:0] lt_set;
  logic [N_LATCH-1:0] lt_clr;
  logic [N_LATCH-1:0] lt_q;
  logic               line_err;
  logic               tmr_evt;
  logic               level_hit;
  logic               tmo_fire;
  logic               st_rx;

  assign line_err = err_overrun | err_parity | err_stop | err_silent;
  assign tmr_evt  = tmr_zero & tmr_run_en & en_q[TMR_BIT];

  assign lt_set = {tmr_evt, line_err};
  assign lt_clr = {stat_rd, lsr_rd};

  irrx_en_reg u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .en_q  (en_q)
  );

  for (genvar gi = 0; gi < N_LATCH; gi++) begin : g_latch
    irrx_evt_latch u_lt (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (lt_set[gi]),
      .clr_i (lt_clr[gi]),
      .q     (lt_q[gi])
    );
  end

  irrx_rx_tmo #(.LVL_W(LVL_W), .TMO_CYC(TMO_CYC)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill      (fill_lvl),
    .thresh    (rx_thresh),
    .byte_in   (byte_in),
    .rbr_rd    (rbr_rd),
    .level_hit (level_hit),
    .tmo_fire  (tmo_fire),
    .st_rx     (st_rx)
  );

  assign en_reg   = en_q;
  assign stat_reg = {5'b00000, lt_q[1], lt_q[0], st_rx};
  assign irq      = irq_merge(en_q, stat_reg);

  assert_glb_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_reg[GLB_BIT] |-> !irq);
  assert_no_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_reg == 8'h00) |-> !irq);
  assert_tmr_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_reg[TMR_BIT] && !(tmr_zero && tmr_run_en && en_reg[TMR_BIT]))
      |=> !stat_reg[TMR_BIT]);
  assert_mask_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && stat_reg[LSR_BIT] && !lsr_rd) |=> stat_reg[LSR_BIT]);
  assert_line_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |=> stat_reg[LSR_BIT]);
endmodule

// File: tb/irrx_irq_ctrl_tb.sv
module irrx_irq_ctrl_tb;
  localparam int unsigned LVL_W = 3;
  localparam int unsigned TMO   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, stat_rd = 0, tmr_run_en = 0, tmr_zero = 0;
  logic err_overrun = 0, err_parity = 0, err_stop = 0, err_silent = 0;
  logic lsr_rd = 0, rbr_rd = 0, byte_in = 0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [LVL_W-1:0] fill_lvl = '0, rx_thresh = '0;
  logic [7:0] en_reg, stat_reg;
  logic irq;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irrx_irq_ctrl #(.LVL_W(LVL_W), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .stat_rd(stat_rd), .tmr_run_en(tmr_run_en), .tmr_zero(tmr_zero),
    .err_overrun(err_overrun), .err_parity(err_parity), .err_stop(err_stop),
    .err_silent(err_silent), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd),
    .byte_in(byte_in), .fill_lvl(fill_lvl), .rx_thresh(rx_thresh),
    .en_reg(en_reg), .stat_reg(stat_reg), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_en(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v;
    tick();
    cfg_we = 0;
  endtask

  function automatic logic [7:0] en_val(input logic g, input logic t,
                                        input logic l, input logic r);
    return {g, 4'b0000, t, l, r};
  endfunction

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset enable", en_reg, 8'h00);
    check("R2 reset status", stat_reg, 8'h00);
    check("R9 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1;
    tick();

    // R1: stored bits and reserved bits
    wr_en(8'hFF); check("R1 write ff", en_reg, 8'h87);
    wr_en(8'h78); check("R1 reserved only", en_reg, 8'h00);
    wr_en(8'h05); check("R1 write 05", en_reg, 8'h05);
    wr_en(8'h00);

    // R6 exhaustive threshold x fill sweep
    for (int t = 1; t < 8; t++) begin
      for (int f = 0; f < 8; f++) begin
        rx_thresh = LVL_W'(t); fill_lvl = '0; rbr_rd = 1;
        tick();
        rbr_rd = 0; fill_lvl = LVL_W'(f);
        tick();
        check("R6 level sweep", {7'd0, stat_reg[0]}, {7'd0, (f >= t)});
        check("R2 reserved bits", {3'd0, stat_reg[7:3]}, 8'h00);
      end
    end
    rx_thresh = '0; fill_lvl = '0;
    tick();
    check("R6 threshold zero", {7'd0, stat_reg[0]}, 8'h01);

    // R8: read clears only below threshold
    rx_thresh = 3'd4; fill_lvl = 3'd6;
    tick();
    fill_lvl = 3'd5; rbr_rd = 1;
    tick();
    rbr_rd = 0;
    check("R8 read above threshold keeps", {7'd0, stat_reg[0]}, 8'h01);
    fill_lvl = 3'd3; rbr_rd = 1;
    tick();
    rbr_rd = 0;
    check("R8 read below threshold clears", {7'd0, stat_reg[0]}, 8'h00);

    // R7: timeout window
    fill_lvl = '0; tick();
    byte_in = 1; fill_lvl = 3'd2;
    tick();
    byte_in = 0;
    for (int k = 1; k <= TMO; k++) begin
      tick();
      check("R7 no early timeout", {7'd0, stat_reg[0]}, 8'h00);
    end
    tick();
    check("R7 timeout sets", {7'd0, stat_reg[0]}, 8'h01);
    rbr_rd = 1;
    tick();
    rbr_rd = 0;
    check("R8 read after timeout clears", {7'd0, stat_reg[0]}, 8'h00);
    // restart midway with a byte
    repeat (TMO - 2) tick();
    byte_in = 1; fill_lvl = 3'd3;
    tick();
    byte_in = 0;
    for (int k = 1; k <= TMO; k++) begin
      tick();
      check("R7 reload delays timeout", {7'd0, stat_reg[0]}, 8'h00);
    end
    tick();
    check("R7 timeout after reload", {7'd0, stat_reg[0]}, 8'h01);
    fill_lvl = '0; rbr_rd = 1;
    tick();
    rbr_rd = 0;

    // R5: each error kind
    for (int e = 0; e < 4; e++) begin
      lsr_rd = 1; tick(); lsr_rd = 0;
      check("R5 cleared", {7'd0, stat_reg[1]}, 8'h00);
      {err_silent, err_stop, err_parity, err_overrun} = 4'(1 << e);
      tick();
      {err_silent, err_stop, err_parity, err_overrun} = 4'h0;
      check("R5 error sets", {7'd0, stat_reg[1]}, 8'h01);
      tick();
      check("R5 holds", {7'd0, stat_reg[1]}, 8'h01);
      lsr_rd = 1; tick(); lsr_rd = 0;
      check("R5 read clears", {7'd0, stat_reg[1]}, 8'h00);
    end
    err_parity = 1; lsr_rd = 1;
    tick();
    err_parity = 0; lsr_rd = 0;
    check("R5 set wins over read", {7'd0, stat_reg[1]}, 8'h01);
    lsr_rd = 1; tick(); lsr_rd = 0;

    // R3: timer gating, all four combinations
    for (int c = 0; c < 4; c++) begin
      stat_rd = 1; tick(); stat_rd = 0;
      tmr_run_en = c[0];
      wr_en(en_val(1'b0, c[1], 1'b0, 1'b0));
      tmr_zero = 1; tick(); tmr_zero = 0;
      check("R3 timer gate", {7'd0, stat_reg[2]}, {7'd0, (c == 3)});
    end
    stat_rd = 1; tick(); stat_rd = 0;
    check("R4 status read clears timer", {7'd0, stat_reg[2]}, 8'h00);
    tmr_zero = 1; stat_rd = 1; tick(); tmr_zero = 0; stat_rd = 0;
    check("R4 set wins over read", {7'd0, stat_reg[2]}, 8'h01);

    // R9/R10: all causes latched, sweep enables
    err_stop = 1; rx_thresh = 3'd1; fill_lvl = 3'd7;
    tick();
    err_stop = 0;
    check("R2 all causes", stat_reg, 8'h07);
    for (int m = 0; m < 16; m++) begin
      wr_en(en_val(m[3], m[2], m[1], m[0]));
      check("R9 irq all set", {7'd0, irq}, {7'd0, m[3] & (m[2] | m[1] | m[0])});
      check("R10 status kept", stat_reg, 8'h07);
    end
    // only receive cause
    stat_rd = 1; lsr_rd = 1; tick(); stat_rd = 0; lsr_rd = 0;
    check("R2 receive only", stat_reg, 8'h01);
    for (int m = 0; m < 16; m++) begin
      wr_en(en_val(m[3], m[2], m[1], m[0]));
      check("R9 irq rx only", {7'd0, irq}, {7'd0, m[3] & m[0]});
    end
    // only line cause
    fill_lvl = '0; rbr_rd = 1; err_overrun = 1;
    tick();
    rbr_rd = 0; err_overrun = 0;
    check("R2 line only", stat_reg, 8'h02);
    for (int m = 0; m < 16; m++) begin
      wr_en(en_val(m[3], m[2], m[1], m[0]));
      check("R9 irq line only", {7'd0, irq}, {7'd0, m[3] & m[1]});
      check("R10 line kept", stat_reg, 8'h02);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule